// File: doc/BRIEF.md
# Hot-Swap Fault and Retry Sequencer

This block is the digital control logic of a hot-swap power switch. It reads comparator flags that are already synchronised to its clock: two supply-undervoltage flags, two enable-valid flags, a current-limit-active flag, the high and low timer-threshold flags, and the output power-good comparator. A strap selects the fault timing source. The block drives the gate enable of the pass switch, the charge and discharge controls of the timer capacitor, and an active-low open-drain power-good pulldown. It also reports its sequencer state.

At power-up, both supplies must be good before enable qualification begins. The supplies and enables must then stay valid for a qualification window before the gate is turned on. A sustained overcurrent leads to shutdown, and after a cooldown the switch restarts by itself. The overcurrent timing comes from one of two sources. With an external capacitor, the timer charges to a high threshold and then discharges to a low threshold. With internal timing, a fixed cycle count is used. In both modes a fixed internal cooldown follows. Every duration is a parameter given in clock cycles.

Top module: `hs_seq_top`

## Requirements
- R1: Reset puts the block in state INIT (code 0) with the gate off. It remains in INIT while either supply flag is low, whatever the enable inputs are. One cycle after both supply flags are good, it enters QUALIFY (code 1).
- R2: In QUALIFY, the gate turns on (state ON, code 2) only after QUAL_CYC consecutive cycles in which both supply and both enable flags are high. An invalid sample restarts the full count.
- R3: In external mode (`tmr_int_sel_i`=0), a current-limit flag seen in ON moves the block to FAULT_CHARGE (code 3). In that state `tmr_chg_o`=1 and `tmr_dis_o`=0, and the gate stays on until the high-threshold flag is seen.
- R4: In external mode, a high-threshold flag during FAULT_CHARGE turns the gate off in the same cycle. On the next cycle the block is in FAULT_DISCHARGE (code 4) with `tmr_dis_o`=1, and it stays there until the low-threshold flag.
- R5: The low-threshold flag moves the block to COOLDOWN (code 5). The gate stays off for exactly COOL_CYC cycles, and then the block returns to ON while the supply and enable flags are valid.
- R6: In external mode, if current limit clears in FAULT_CHARGE before the high threshold is reached, the block returns to ON with the gate still on. Outside FAULT_CHARGE the external timer is held in discharge (`tmr_dis_o`=1, `tmr_chg_o`=0).
- R7: In internal mode (`tmr_int_sel_i`=1), FAULT_CHARGE lasts OC_CYC cycles of continuous current limit with the gate on, and then COOLDOWN follows directly. The timer threshold flags are ignored, and `tmr_chg_o` and `tmr_dis_o` stay 0.
- R8: In internal mode, if current limit clears before OC_CYC cycles, the block returns to ON with the gate kept on, and the overcurrent count is cleared.
- R9: If an enable flag goes low in any powered state, the gate turns off in the same cycle and the next state is QUALIFY. If a supply flag goes low, the gate turns off in the same cycle and the next state is INIT.
- R10: `pg_n_o` is low only when the gate enable is on and `pg_cmp_i` is high. In every other case it is released high.
- R11: `state_o` only ever carries one of the six codes 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_in_ok_i | input | 1 | Input supply above undervoltage threshold |
| uv_int_ok_i | input | 1 | Internal supply above undervoltage threshold |
| en1_ok_i | input | 1 | First enable input valid |
| en2_ok_i | input | 1 | Second enable input valid |
| ilim_i | input | 1 | Current limit loop active |
| tmr_hi_i | input | 1 | Timer capacitor above high threshold |
| tmr_lo_i | input | 1 | Timer capacitor below low threshold |
| pg_cmp_i | input | 1 | Output voltage comparator good |
| tmr_int_sel_i | input | 1 | Strap: 1 selects internal fault timing |
| gate_en_o | output | 1 | Pass-switch gate enable |
| tmr_chg_o | output | 1 | Timer capacitor charge source on |
| tmr_dis_o | output | 1 | Timer capacitor discharge source on |
| pg_n_o | output | 1 | Power-good pulldown, low = power good |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench sweeps the position of a single invalid enable sample across the whole qualification window. A design that only pauses the count, or that ignores a glitch near the end of the window, would turn the gate on early. In external mode it varies the number of charge cycles that come before the high threshold, checks that the gate drops in the same cycle as the high threshold, and checks that the cooldown length is exact to the cycle. In internal mode it sweeps the current-limit pulse length across the OC_CYC boundary while holding both timer flags high. A design that miscounts, keeps a stale count, or listens to the flags would shut down on the wrong pulse or drive the timer pins. Supply and enable loss are injected from the ON and FAULT_CHARGE states to check the same-cycle gate kill and the return state.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_QUAL = 3'd1,
    ST_ON   = 3'd2,
    ST_FCHG = 3'd3,
    ST_FDIS = 3'd4,
    ST_COOL = 3'd5
  } hs_state_e;
endpackage

// File: rtl/hs_cycle_timer.sv
module hs_cycle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  // count clears whenever run drops, so every window is consecutive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hs_out_drv.sv
module hs_out_drv
  import hs_seq_pkg::*;
(
  input  hs_state_e st_i,
  input  logic      cond_ok_i,
  input  logic      ext_mode_i,
  input  logic      tmr_hi_i,
  input  logic      pg_cmp_i,
  output logic      gate_en_o,
  output logic      tmr_chg_o,
  output logic      tmr_dis_o,
  output logic      pg_n_o
);
  logic hi_kill;

  assign hi_kill   = ext_mode_i && tmr_hi_i;
  // gate drops combinationally on lost conditions or high threshold
  assign gate_en_o = cond_ok_i &&
                     ((st_i == ST_ON) || ((st_i == ST_FCHG) && !hi_kill));
  assign tmr_chg_o = ext_mode_i && cond_ok_i && (st_i == ST_FCHG) && !tmr_hi_i;
  assign tmr_dis_o = ext_mode_i && !tmr_chg_o;
  assign pg_n_o    = !(gate_en_o && pg_cmp_i);
endmodule

// File: rtl/hs_seq_top.sv
module hs_seq_top
  import hs_seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 12_500_000,
  parameter int unsigned OC_CYC   = 250_000,
  parameter int unsigned COOL_CYC = 12_500_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_in_ok_i,
  input  logic       uv_int_ok_i,
  input  logic       en1_ok_i,
  input  logic       en2_ok_i,
  input  logic       ilim_i,
  input  logic       tmr_hi_i,
  input  logic       tmr_lo_i,
  input  logic       pg_cmp_i,
  input  logic       tmr_int_sel_i,
  output logic       gate_en_o,
  output logic       tmr_chg_o,
  output logic       tmr_dis_o,
  output logic       pg_n_o,
  output logic [2:0] state_o
);
  hs_state_e st_q, st_d;
  logic supply_ok, cond_ok, ext_mode;
  logic qual_done, oc_done, cool_done;

  assign supply_ok = uv_in_ok_i && uv_int_ok_i;
  assign cond_ok   = supply_ok && en1_ok_i && en2_ok_i;
  assign ext_mode  = !tmr_int_sel_i;

  hs_cycle_timer #(.LIMIT(QUAL_CYC)) u_qual_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i ((st_q == ST_QUAL) && cond_ok),
    .done_o(qual_done)
  );

  hs_cycle_timer #(.LIMIT(OC_CYC)) u_oc_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i ((st_q == ST_FCHG) && ilim_i && !ext_mode),
    .done_o(oc_done)
  );

  hs_cycle_timer #(.LIMIT(COOL_CYC)) u_cool_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == ST_COOL),
    .done_o(cool_done)
  );

  always_comb begin
    st_d = st_q;
    if (!supply_ok) begin
      st_d = ST_INIT;
    end else if (st_q == ST_INIT) begin
      st_d = ST_QUAL;
    end else if (st_q == ST_QUAL) begin
      if (qual_done) st_d = ST_ON;
    end else if (!cond_ok) begin
      st_d = ST_QUAL;
    end else begin
      case (st_q)
        ST_ON:   if (ilim_i) st_d = ST_FCHG;
        ST_FCHG: begin
          if (ext_mode) begin
            if (tmr_hi_i)     st_d = ST_FDIS;
            else if (!ilim_i) st_d = ST_ON;
          end else begin
            if (oc_done)      st_d = ST_COOL;
            else if (!ilim_i) st_d = ST_ON;
          end
        end
        ST_FDIS: if (!ext_mode || tmr_lo_i) st_d = ST_COOL;
        ST_COOL: if (cool_done) st_d = ST_ON;
        default: st_d = ST_INIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INIT;
    else         st_q <= st_d;
  end

  hs_out_drv u_out_drv (
    .st_i      (st_q),
    .cond_ok_i (cond_ok),
    .ext_mode_i(ext_mode),
    .tmr_hi_i  (tmr_hi_i),
    .pg_cmp_i  (pg_cmp_i),
    .gate_en_o (gate_en_o),
    .tmr_chg_o (tmr_chg_o),
    .tmr_dis_o (tmr_dis_o),
    .pg_n_o    (pg_n_o)
  );

  assign state_o = st_q;
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uv_in_ok_i,
  input logic       uv_int_ok_i,
  input logic       en1_ok_i,
  input logic       en2_ok_i,
  input logic       ilim_i,
  input logic       tmr_hi_i,
  input logic       tmr_lo_i,
  input logic       pg_cmp_i,
  input logic       tmr_int_sel_i,
  input logic       gate_en_o,
  input logic       tmr_chg_o,
  input logic       tmr_dis_o,
  input logic       pg_n_o,
  input logic [2:0] state_o
);
  logic sup_ok, all_ok;
  assign sup_ok = uv_in_ok_i && uv_int_ok_i;
  assign all_ok = sup_ok && en1_ok_i && en2_ok_i;

  // R1
  init_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_ok |=> (state_o == 3'd0));

  // R2
  qual_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) && sup_ok && !all_ok |=> (state_o == 3'd1) && !gate_en_o);

  // R3
  charge_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) && !tmr_int_sel_i && !tmr_hi_i && all_ok
      |-> tmr_chg_o && !tmr_dis_o && gate_en_o);

  // R4
  fdis_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> !gate_en_o && (tmr_int_sel_i || tmr_dis_o));

  // R4
  hi_to_fdis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) && !tmr_int_sel_i && tmr_hi_i && all_ok |=> (state_o == 3'd4));

  // R5
  cool_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5) |-> !gate_en_o);

  // R6
  clear_to_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) && !tmr_int_sel_i && !tmr_hi_i && !ilim_i && all_ok
      |=> (state_o == 3'd2));

  // R7
  int_no_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_int_sel_i |-> !tmr_chg_o && !tmr_dis_o);

  // R9
  cond_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_ok |-> !gate_en_o);

  // R10
  pg_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_n_o |-> gate_en_o && pg_cmp_i);

  // R11
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);

  // R5
  lo_to_cool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) && all_ok && (tmr_lo_i || tmr_int_sel_i) |=> (state_o == 3'd5));
endmodule

bind hs_seq_top hs_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .uv_in_ok_i   (uv_in_ok_i),
  .uv_int_ok_i  (uv_int_ok_i),
  .en1_ok_i     (en1_ok_i),
  .en2_ok_i     (en2_ok_i),
  .ilim_i       (ilim_i),
  .tmr_hi_i     (tmr_hi_i),
  .tmr_lo_i     (tmr_lo_i),
  .pg_cmp_i     (pg_cmp_i),
  .tmr_int_sel_i(tmr_int_sel_i),
  .gate_en_o    (gate_en_o),
  .tmr_chg_o    (tmr_chg_o),
  .tmr_dis_o    (tmr_dis_o),
  .pg_n_o       (pg_n_o),
  .state_o      (state_o)
);

// File: tb/hs_seq_top_tb.sv
module hs_seq_top_tb;
  localparam int QUAL = 6;
  localparam int OC   = 4;
  localparam int COOL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_in = 1'b1, uv_int = 1'b1, en1 = 1'b1, en2 = 1'b1;
  logic ilim = 1'b0, hi = 1'b0, lo = 1'b0, pgc = 1'b0, isel = 1'b0;
  logic gate, chg, dis, pg_n;
  logic [2:0] st;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hs_seq_top #(.QUAL_CYC(QUAL), .OC_CYC(OC), .COOL_CYC(COOL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .uv_in_ok_i(uv_in), .uv_int_ok_i(uv_int),
    .en1_ok_i(en1), .en2_ok_i(en2),
    .ilim_i(ilim), .tmr_hi_i(hi), .tmr_lo_i(lo),
    .pg_cmp_i(pgc), .tmr_int_sel_i(isel),
    .gate_en_o(gate), .tmr_chg_o(chg), .tmr_dis_o(dis),
    .pg_n_o(pg_n), .state_o(st)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_sg(input string req, input int es, input int eg);
    chk({req, " state"}, int'(st), es);
    chk({req, " gate"}, int'(gate), eg);
  endtask

  // from QUALIFY with all flags valid: QUAL cycles gate off, then ON
  task automatic run_qual(input string req);
    for (int i = 0; i < QUAL; i++) begin
      chk_sg(req, 1, 0);
      tick();
    end
    chk_sg(req, 2, 1);
  endtask

  task automatic run_cool(input string req);
    for (int i = 0; i < COOL; i++) begin
      chk_sg(req, 5, 0);
      tick();
    end
    chk_sg(req, 2, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    uv_in = 1'b0;
    #3;
    chk_sg("R1 reset", 0, 0);
    chk("R10 reset pg", int'(pg_n), 1);
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_sg("R1 uv_in low", 0, 0);
    end
    uv_in = 1'b1; uv_int = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_sg("R1 uv_int low", 0, 0);
    end
    uv_int = 1'b1;
    tick();
    // R2 clean qualification
    run_qual("R2 clean");
    pgc = 1'b1; #1;
    chk("R10 pg good", int'(pg_n), 0);
    pgc = 1'b0; #1;
    chk("R10 pg cmp low", int'(pg_n), 1);
    chk("R6 idle discharge", int'(dis), 1);
    chk("R6 idle no charge", int'(chg), 0);

    // R2 glitch position sweep, R9 enable loss from ON
    for (int g = 0; g < QUAL; g++) begin
      en2 = 1'b0; pgc = 1'b1; #1;
      chk("R9 en loss gate", int'(gate), 0);
      chk("R10 pg forced off", int'(pg_n), 1);
      pgc = 1'b0;
      tick();
      chk_sg("R9 en loss state", 1, 0);
      en2 = 1'b1;
      for (int i = 0; i < g; i++) tick();
      en1 = 1'b0;
      tick();
      chk_sg("R2 glitch", 1, 0);
      en1 = 1'b1;
      run_qual("R2 restart");
    end

    // R3 R4 R5 external fault sweep over charge length
    for (int n = 0; n < 4; n++) begin
      ilim = 1'b1;
      tick();
      for (int i = 0; i < n; i++) begin
        chk_sg("R3 charging", 3, 1);
        chk("R3 chg", int'(chg), 1);
        chk("R3 dis", int'(dis), 0);
        tick();
      end
      hi = 1'b1; #1;
      chk("R4 gate kill", int'(gate), 0);
      chk("R4 chg off", int'(chg), 0);
      tick();
      chk_sg("R4 fdis", 4, 0);
      chk("R4 dis", int'(dis), 1);
      hi = 1'b0; ilim = 1'b0;
      tick(); tick();
      chk_sg("R4 wait lo", 4, 0);
      lo = 1'b1;
      tick();
      lo = 1'b0;
      run_cool("R5 cooldown");
    end

    // R6 current limit clears before high threshold
    ilim = 1'b1;
    tick(); tick();
    chk_sg("R6 fchg", 3, 1);
    ilim = 1'b0; #1;
    chk("R6 gate held", int'(gate), 1);
    tick();
    chk_sg("R6 back on", 2, 1);
    chk("R6 discharge", int'(dis), 1);

    // R9 enable loss during external fault charge
    ilim = 1'b1;
    tick();
    en1 = 1'b0; #1;
    chk("R9 fchg gate", int'(gate), 0);
    chk("R9 fchg chg", int'(chg), 0);
    chk("R9 fchg dis", int'(dis), 1);
    tick();
    chk_sg("R9 fchg state", 1, 0);
    en1 = 1'b1; ilim = 1'b0;
    run_qual("R2 after fault");

    // R7 R8 internal mode pulse-length sweep, threshold flags held high
    isel = 1'b1; hi = 1'b1; lo = 1'b1;
    for (int p = 1; p <= OC + 2; p++) begin
      ilim = 1'b1;
      tick();
      for (int i = 0; i < ((p - 1 < OC) ? p - 1 : OC); i++) begin
        chk_sg("R7 int fchg", 3, 1);
        chk("R7 no chg", int'(chg), 0);
        chk("R7 no dis", int'(dis), 0);
        tick();
      end
      if (p - 1 >= OC) begin
        ilim = 1'b0;
        run_cool("R7 int cooldown");
      end else begin
        ilim = 1'b0; #1;
        chk_sg("R8 clear held", 3, 1);
        tick();
        chk_sg("R8 back on", 2, 1);
      end
    end
    hi = 1'b0; lo = 1'b0; isel = 1'b0;

    // R9 supply loss from ON
    uv_int = 1'b0; #1;
    chk("R9 uv gate", int'(gate), 0);
    tick();
    chk_sg("R9 uv state", 0, 0);
    uv_int = 1'b1;
    tick();
    run_qual("R1 requalify");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule